// File: doc/BRIEF.md
# Cross-Lane Word Access Merger

This unit sits between four vector lanes and a banked data cache. In any cycle each lane may offer one 32-bit load or store for a microthread. The unit picks the pending request of the lowest-numbered lane as the leader. All pending requests of the same kind that fall in the leader's aligned 128-bit block are folded into one wide cache request. A lane that was not included keeps its request held and competes again in a later cycle. With unit-stride traffic across the lanes, one cache access serves all four lanes where four separate accesses would otherwise conflict on the cache banks.

Stores are merged into a single 128-bit write. Each participating lane's word goes into its slot, and a 16-bit byte-enable marks the slots that are written. Loads record which lanes took part and which word each one wants. When the cache returns the 128-bit block, in the order the requests were issued, every participating lane receives its own word. The cache's four banks are interleaved on 64-byte lines, so the unit also outputs the bank index of each request.

Top module: `lane_coalescer`

## Requirements
- R1: While reset is asserted and after it is released with no lane request, `creq_valid`, `lane_ready` and `lane_rsp_valid` are all zero.
- R2: Two requests share a block when address bits [31:4] are equal. `creq_addr` is the leader's address with bits [3:0] cleared, and `creq_bank` equals `creq_addr[7:6]`.
- R3: The lowest-numbered valid lane leads. Every valid lane whose block and kind match the leader's is accepted in the same cycle. Other lanes stay pending and are served in later cycles.
- R4: Four lanes accessing four consecutive words of one block, in any lane order, are served by a single cache request with `creq_be` = 16'hFFFF.
- R5: For every accepted lane with word slot s = addr[3:2], `creq_be` bits [4s+3:4s] are set. For a store, `creq_wdata` bits [32s+31:32s] carry that lane's data. All other byte-enable bits are zero.
- R6: A store whose slot is already taken by a lower-numbered accepted store in the same block is deferred to a later request.
- R7: Loads and stores are never merged. A lane whose kind (`lane_we`, 1 = store) differs from the leader's is deferred.
- R8: `lane_ready[i]` is high only in a cycle where lane i's request is part of a request with `creq_valid` and `creq_ready` both high. A lane that is not accepted keeps its request offered.
- R9: One cycle after a `crsp_valid` beat, `lane_rsp_valid` has a bit set for each lane of the corresponding load request. Each such lane's `lane_rsp_data` is the word of `crsp_data` at that lane's slot addr[3:2]. Loads from the same word by several lanes all receive it.
- R10: Load responses reach the lanes in issue order. At most DEPTH (4) load requests may be outstanding. While that many are outstanding, no load is issued, but a store can still issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_valid | input | 4 | Per-lane request present |
| lane_ready | output | 4 | Per-lane request accepted this cycle |
| lane_we | input | 4 | Per-lane kind, 1 = store |
| lane_addr | input | 128 | Per-lane byte address, lane i at bits [32i+31:32i] |
| lane_wdata | input | 128 | Per-lane store word, lane i at bits [32i+31:32i] |
| lane_rsp_valid | output | 4 | Per-lane load data valid |
| lane_rsp_data | output | 128 | Per-lane load word, lane i at bits [32i+31:32i] |
| creq_valid | output | 1 | Wide cache request present |
| creq_ready | input | 1 | Cache accepts the request |
| creq_we | output | 1 | Wide request is a store |
| creq_addr | output | 32 | Block-aligned request address |
| creq_bank | output | 2 | Cache bank index of the request |
| creq_be | output | 16 | Byte enables of the slots taking part |
| creq_wdata | output | 128 | Merged store data |
| crsp_valid | input | 1 | Cache load response beat |
| crsp_data | input | 128 | 128-bit load response block |

## Verification
The assertions check on every cycle the rules that hold cycle by cycle. An accepted lane always lies in the issued block. Lane 0 is never skipped when it is valid and the cache is ready. A refused request stays stable until accepted. The response tracker never overflows, and lane responses appear only after a cache beat. Merge outcomes for concrete address mixes can only be shown by the bench scenarios. These include byte-enable and data placement, deferral of slot conflicts and mixed kinds, and the order and content of the steered load words. Stalling at the outstanding-load limit, and releasing after the first response, are also shown only by the bench.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic {OP_LD = 1'b0, OP_ST = 1'b1} op_e;
endpackage

// File: rtl/coal_pick.sv
module coal_pick #(
  parameter int NLANE    = 4,
  parameter int AW       = 32,
  parameter int OFS_W    = 4,
  parameter int SLOT_W   = 2,
  parameter int BYTE_LSB = 2
) (
  input  logic [NLANE-1:0]    lane_valid,
  input  logic [NLANE-1:0]    lane_we,
  input  logic [NLANE*AW-1:0] lane_addr,
  output logic                any_v,
  output logic                lead_we,
  output logic [AW-1:0]       lead_addr,
  output logic [NLANE-1:0]    served
);
  localparam int IDX_W  = (NLANE > 1) ? $clog2(NLANE) : 1;
  localparam int NSLOT  = 1 << SLOT_W;

  logic [AW-1:0]       a [NLANE];
  logic [IDX_W-1:0]    lead_idx;
  logic [AW-OFS_W-1:0] lead_tag;
  logic [NSLOT-1:0]    used;

  for (genvar g = 0; g < NLANE; g++) begin : g_split
    assign a[g] = lane_addr[g*AW +: AW];
  end

  always_comb begin
    any_v    = 1'b0;
    lead_idx = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (lane_valid[i] && !any_v) begin
        any_v    = 1'b1;
        lead_idx = IDX_W'(i);
      end
    end
    lead_tag  = a[lead_idx][AW-1:OFS_W];
    lead_we   = lane_we[lead_idx];
    lead_addr = {lead_tag, {OFS_W{1'b0}}};
    used      = '0;
    served    = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (lane_valid[i] && (a[i][AW-1:OFS_W] == lead_tag) && (lane_we[i] == lead_we)) begin
        if (!(lead_we && used[a[i][BYTE_LSB +: SLOT_W]])) begin
          served[i]                      = 1'b1;
          used[a[i][BYTE_LSB +: SLOT_W]] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/coal_pack.sv
module coal_pack #(
  parameter int NLANE    = 4,
  parameter int AW       = 32,
  parameter int WORD_W   = 32,
  parameter int SLOT_W   = 2,
  parameter int BYTE_LSB = 2
) (
  input  logic [NLANE-1:0]                        served,
  input  logic [NLANE*AW-1:0]                     lane_addr,
  input  logic [NLANE*WORD_W-1:0]                 lane_wdata,
  output logic [(WORD_W/8)*(1<<SLOT_W)-1:0]       be,
  output logic [WORD_W*(1<<SLOT_W)-1:0]           wdata
);
  localparam int WB = WORD_W / 8;

  always_comb begin
    be    = '0;
    wdata = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (served[i]) begin
        be[int'(lane_addr[i*AW+BYTE_LSB +: SLOT_W])*WB +: WB]        = '1;
        wdata[int'(lane_addr[i*AW+BYTE_LSB +: SLOT_W])*WORD_W +: WORD_W] =
          lane_wdata[i*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/coal_track.sv
module coal_track #(
  parameter int NLANE  = 4,
  parameter int WORD_W = 32,
  parameter int SLOT_W = 2,
  parameter int DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [NLANE-1:0]             push_mask,
  input  logic [NLANE*SLOT_W-1:0]      push_slots,
  output logic                         full,
  input  logic                         crsp_valid,
  input  logic [WORD_W*(1<<SLOT_W)-1:0] crsp_data,
  output logic [NLANE-1:0]             rsp_valid,
  output logic [NLANE*WORD_W-1:0]      rsp_data
);
  // DEPTH must be a power of two so the pointers wrap naturally
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [NLANE-1:0]        mask_mem [DEPTH];
  logic [NLANE*SLOT_W-1:0] slot_mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_nx, rptr_q, rptr_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          pop;
  logic [NLANE-1:0]        rv_nx;
  logic [NLANE*WORD_W-1:0] rd_nx;

  assign full = (cnt_q == CW'(DEPTH));
  assign pop  = crsp_valid && (cnt_q != '0);

  always_comb begin
    wptr_nx = wptr_q + PW'(push);
    rptr_nx = rptr_q + PW'(pop);
    cnt_nx  = cnt_q + CW'(push) - CW'(pop);
    rv_nx   = pop ? mask_mem[rptr_q] : '0;
    rd_nx   = '0;
    for (int i = 0; i < NLANE; i++) begin
      rd_nx[i*WORD_W +: WORD_W] =
        crsp_data[int'(slot_mem[rptr_q][i*SLOT_W +: SLOT_W])*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mask_mem[wptr_q] <= push_mask;
      slot_mem[wptr_q] <= push_slots;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      cnt_q     <= '0;
      rsp_valid <= '0;
    end else begin
      wptr_q    <= wptr_nx;
      rptr_q    <= rptr_nx;
      cnt_q     <= cnt_nx;
      rsp_valid <= rv_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (pop) rsp_data <= rd_nx;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R10
  AST_RSP_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    crsp_valid |=> (rsp_valid != '0)); // R9
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !crsp_valid |=> (rsp_valid == '0)); // R9
endmodule

// File: rtl/lane_coalescer.sv
module lane_coalescer #(
  parameter int NLANE      = 4,
  parameter int AW         = 32,
  parameter int WORD_W     = 32,
  parameter int BLK_W      = 128,
  parameter int DEPTH      = 4,
  parameter int NBANK      = 4,
  parameter int LINE_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLANE-1:0]        lane_valid,
  output logic [NLANE-1:0]        lane_ready,
  input  logic [NLANE-1:0]        lane_we,
  input  logic [NLANE*AW-1:0]     lane_addr,
  input  logic [NLANE*WORD_W-1:0] lane_wdata,
  output logic [NLANE-1:0]        lane_rsp_valid,
  output logic [NLANE*WORD_W-1:0] lane_rsp_data,
  output logic                    creq_valid,
  input  logic                    creq_ready,
  output logic                    creq_we,
  output logic [AW-1:0]           creq_addr,
  output logic [$clog2(NBANK)-1:0] creq_bank,
  output logic [BLK_W/8-1:0]      creq_be,
  output logic [BLK_W-1:0]        creq_wdata,
  input  logic                    crsp_valid,
  input  logic [BLK_W-1:0]        crsp_data
);
  import coal_pkg::*;

  localparam int WPB      = BLK_W / WORD_W;
  localparam int SLOT_W   = $clog2(WPB);
  localparam int OFS_W    = $clog2(BLK_W / 8);
  localparam int BYTE_LSB = $clog2(WORD_W / 8);
  localparam int BANK_LSB = $clog2(LINE_BYTES);
  localparam int BANK_W   = $clog2(NBANK);

  logic                     any_v, lead_we, full, issue, push;
  logic [AW-1:0]            lead_addr;
  logic [NLANE-1:0]         served;
  logic [NLANE*SLOT_W-1:0]  slots;
  op_e                      lead_op;

  coal_pick #(.NLANE(NLANE), .AW(AW), .OFS_W(OFS_W), .SLOT_W(SLOT_W),
              .BYTE_LSB(BYTE_LSB)) u_pick (
    .lane_valid(lane_valid), .lane_we(lane_we), .lane_addr(lane_addr),
    .any_v(any_v), .lead_we(lead_we), .lead_addr(lead_addr), .served(served));

  coal_pack #(.NLANE(NLANE), .AW(AW), .WORD_W(WORD_W), .SLOT_W(SLOT_W),
              .BYTE_LSB(BYTE_LSB)) u_pack (
    .served(served), .lane_addr(lane_addr), .lane_wdata(lane_wdata),
    .be(creq_be), .wdata(creq_wdata));

  for (genvar g = 0; g < NLANE; g++) begin : g_slot
    assign slots[g*SLOT_W +: SLOT_W] = lane_addr[g*AW+BYTE_LSB +: SLOT_W];
  end

  assign lead_op    = op_e'(lead_we);
  assign creq_valid = any_v && ((lead_op == OP_ST) || !full);
  assign creq_we    = (lead_op == OP_ST);
  assign creq_addr  = lead_addr;
  assign creq_bank  = lead_addr[BANK_LSB +: BANK_W];
  assign issue      = creq_valid && creq_ready;
  assign lane_ready = served & {NLANE{issue}};
  assign push       = issue && (lead_op == OP_LD);

  coal_track #(.NLANE(NLANE), .WORD_W(WORD_W), .SLOT_W(SLOT_W), .DEPTH(DEPTH)) u_track (
    .clk(clk), .rst_n(rst_n), .push(push), .push_mask(served), .push_slots(slots),
    .full(full), .crsp_valid(crsp_valid), .crsp_data(crsp_data),
    .rsp_valid(lane_rsp_valid), .rsp_data(lane_rsp_data));

  for (genvar g = 0; g < NLANE; g++) begin : g_chk
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      lane_valid[g] |-> (lane_addr[g*AW +: BYTE_LSB] == '0)); // R2
    AST_READY_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      lane_ready[g] |-> (lane_valid[g] && creq_valid && creq_ready &&
                         lane_addr[g*AW+OFS_W +: AW-OFS_W] == creq_addr[AW-1:OFS_W])); // R8
    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_valid[g] && !lane_ready[g]) |=> (lane_valid[g] && $stable(lane_addr[g*AW +: AW]))); // R8
  end

  AST_LANE0_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    (creq_valid && creq_ready && lane_valid[0]) |-> lane_ready[0]); // R3
  AST_ISSUE_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
    (creq_valid && creq_ready) |-> (lane_ready != '0)); // R3
  AST_ALIGNED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    creq_valid |-> (creq_addr[OFS_W-1:0] == '0)); // R2
endmodule

// File: tb/sim_lane_coalescer.sv
module sim_lane_coalescer;
  typedef struct packed {
    logic [3:0]  vld;
    logic        we;
    logic [31:0] a0, a1, a2, a3;
    logic [3:0]  rdy;
    logic [31:0] eaddr;
    logic [15:0] ebe;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{4'hF, 1'b0, 32'h1000, 32'h1004, 32'h1008, 32'h100C, 4'hF, 32'h1000, 16'hFFFF},
    '{4'hF, 1'b1, 32'h2040, 32'h2044, 32'h2048, 32'h204C, 4'hF, 32'h2040, 16'hFFFF},
    '{4'hF, 1'b0, 32'h30CC, 32'h30C8, 32'h30C4, 32'h30C0, 4'hF, 32'h30C0, 16'hFFFF},
    '{4'hF, 1'b0, 32'h4008, 32'h4008, 32'h4008, 32'h4008, 4'hF, 32'h4000, 16'h0F00},
    '{4'h4, 1'b1, 32'h0,    32'h0,    32'h5084, 32'h0,    4'h4, 32'h5080, 16'h00F0},
    '{4'h9, 1'b0, 32'h60A0, 32'h0,    32'h0,    32'h60AC, 4'h9, 32'h60A0, 16'hF00F}
  };

  logic         clk, rst_n;
  logic [3:0]   lv, lwe, lane_ready, lane_rsp_valid;
  logic [31:0]  la [4];
  logic [31:0]  lwd [4];
  logic [127:0] lane_addr, lane_wdata, lane_rsp_data, creq_wdata, crsp_data;
  logic         creq_valid, creq_ready, creq_we, crsp_valid;
  logic [31:0]  creq_addr;
  logic [1:0]   creq_bank;
  logic [15:0]  creq_be;
  int n_chk, n_err;
  bit done;

  assign lane_addr  = {la[3], la[2], la[1], la[0]};
  assign lane_wdata = {lwd[3], lwd[2], lwd[1], lwd[0]};

  lane_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .lane_valid(lv), .lane_ready(lane_ready), .lane_we(lwe),
    .lane_addr(lane_addr), .lane_wdata(lane_wdata), .lane_rsp_valid(lane_rsp_valid),
    .lane_rsp_data(lane_rsp_data), .creq_valid(creq_valid), .creq_ready(creq_ready),
    .creq_we(creq_we), .creq_addr(creq_addr), .creq_bank(creq_bank), .creq_be(creq_be),
    .creq_wdata(creq_wdata), .crsp_valid(crsp_valid), .crsp_data(crsp_data));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] rw(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hCAFE_0000;
  endfunction
  function automatic logic [31:0] wd(input int lane, input int tag);
    return 32'h5A00_0000 + 32'(tag * 16 + lane);
  endfunction

  task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic idle_lanes();
    lv = '0; lwe = '0;
    for (int i = 0; i < 4; i++) begin la[i] = '0; lwd[i] = '0; end
  endtask

  task automatic set_lane(input int i, input logic v, input logic w, input logic [31:0] a, input int tag);
    lv[i] = v; lwe[i] = w; la[i] = a; lwd[i] = wd(i, tag);
  endtask

  // cache beat for block blk; checks steering for lanes in mask one cycle later
  task automatic do_rsp(input string rq, input logic [31:0] blk, input logic [3:0] mask,
                        input logic [31:0] a0, a1, a2, a3);
    logic [31:0] ea [4];
    ea[0] = a0; ea[1] = a1; ea[2] = a2; ea[3] = a3;
    @(negedge clk);
    crsp_valid = 1'b1;
    for (int k = 0; k < 4; k++) crsp_data[k*32 +: 32] = rw(blk + 32'(4*k));
    @(negedge clk);
    crsp_valid = 1'b0;
    #1;
    chk(rq, 128'(lane_rsp_valid), 128'(mask));
    for (int i = 0; i < 4; i++)
      if (mask[i]) chk(rq, 128'(lane_rsp_data[i*32 +: 32]), 128'(rw(ea[i])));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; done = 0;
    rst_n = 1'b0; creq_ready = 1'b1; crsp_valid = 1'b0; crsp_data = '0;
    idle_lanes();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset creq_valid", 128'(creq_valid), 128'(0));
    chk("R1 reset rsp_valid", 128'(lane_rsp_valid), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 idle creq_valid", 128'(creq_valid), 128'(0));
    chk("R1 idle ready", 128'(lane_ready), 128'(0));
    chk("R1 idle rsp_valid", 128'(lane_rsp_valid), 128'(0));

    // table walk: R2 R4 R5 R9 R11-style duplicates (R9)
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic [31:0] aa [4];
      t = VEC[v];
      aa[0] = t.a0; aa[1] = t.a1; aa[2] = t.a2; aa[3] = t.a3;
      @(negedge clk);
      for (int i = 0; i < 4; i++) set_lane(i, t.vld[i], t.we, aa[i], v);
      #1;
      chk("R2 creq_valid", 128'(creq_valid), 128'(1));
      chk("R4 ready mask", 128'(lane_ready), 128'(t.rdy));
      chk("R2 creq_addr", 128'(creq_addr), 128'(t.eaddr));
      chk("R2 creq_bank", 128'(creq_bank), 128'(t.eaddr[7:6]));
      chk("R5 creq_be", 128'(creq_be), 128'(t.ebe));
      chk("R7 creq_we", 128'(creq_we), 128'(t.we));
      if (t.we)
        for (int i = 0; i < 4; i++)
          if (t.rdy[i]) chk("R5 store word", 128'(creq_wdata[aa[i][3:2]*32 +: 32]), 128'(wd(i, v)));
      @(negedge clk);
      idle_lanes();
      if (!t.we) do_rsp("R9 steering", t.eaddr, t.rdy, aa[0], aa[1], aa[2], aa[3]);
    end

    // R3 leader priority, deferred lane, R10 order
    @(negedge clk);
    set_lane(1, 1, 0, 32'h7000, 0); set_lane(2, 1, 0, 32'h8000, 0); set_lane(3, 1, 0, 32'h7008, 0);
    #1;
    chk("R3 first group", 128'(lane_ready), 128'(4'hA));
    chk("R3 first addr", 128'(creq_addr), 128'(32'h7000));
    @(negedge clk);
    lv[1] = 0; lv[3] = 0;
    #1;
    chk("R3 deferred lane", 128'(lane_ready), 128'(4'h4));
    chk("R3 second addr", 128'(creq_addr), 128'(32'h8000));
    @(negedge clk);
    idle_lanes();
    do_rsp("R10 order first", 32'h7000, 4'hA, 0, 32'h7000, 0, 32'h7008);
    do_rsp("R10 order second", 32'h8000, 4'h4, 0, 0, 32'h8000, 0);

    // R6 store slot conflict
    @(negedge clk);
    set_lane(0, 1, 1, 32'h9004, 7); set_lane(1, 1, 1, 32'h9008, 7); set_lane(2, 1, 1, 32'h9004, 7);
    #1;
    chk("R6 conflict ready", 128'(lane_ready), 128'(4'h3));
    chk("R6 conflict be", 128'(creq_be), 128'(16'h0FF0));
    chk("R6 slot1 data", 128'(creq_wdata[63:32]), 128'(wd(0, 7)));
    @(negedge clk);
    lv[0] = 0; lv[1] = 0;
    #1;
    chk("R6 deferred store", 128'(lane_ready), 128'(4'h4));
    chk("R6 deferred data", 128'(creq_wdata[63:32]), 128'(wd(2, 7)));
    @(negedge clk);
    idle_lanes();

    // R7 mixed kinds
    @(negedge clk);
    set_lane(0, 1, 0, 32'hA000, 8); set_lane(1, 1, 1, 32'hA004, 8);
    #1;
    chk("R7 load first", 128'(lane_ready), 128'(4'h1));
    chk("R7 load we", 128'(creq_we), 128'(0));
    @(negedge clk);
    lv[0] = 0;
    #1;
    chk("R7 store later", 128'(lane_ready), 128'(4'h2));
    chk("R7 store we", 128'(creq_we), 128'(1));
    @(negedge clk);
    idle_lanes();
    do_rsp("R7 load data", 32'hA000, 4'h1, 32'hA000, 0, 0, 0);

    // R8 backpressure
    @(negedge clk);
    creq_ready = 0;
    set_lane(0, 1, 0, 32'hC004, 9); set_lane(1, 1, 0, 32'hC008, 9);
    #1;
    chk("R8 stalled valid", 128'(creq_valid), 128'(1));
    chk("R8 stalled ready", 128'(lane_ready), 128'(0));
    @(negedge clk);
    #1;
    chk("R8 still held", 128'(lane_ready), 128'(0));
    creq_ready = 1;
    #1;
    chk("R8 accepted", 128'(lane_ready), 128'(4'h3));
    @(negedge clk);
    idle_lanes();
    do_rsp("R8 load data", 32'hC000, 4'h3, 32'hC004, 32'hC008, 0, 0);

    // R10 outstanding limit
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      set_lane(0, 1, 0, 32'hB000 + 32'(16*k), 0);
      #1;
      chk("R10 fill", 128'(lane_ready), 128'(4'h1));
    end
    @(negedge clk);
    idle_lanes();
    set_lane(1, 1, 1, 32'hE000, 3);
    #1;
    chk("R10 store while full", 128'(lane_ready), 128'(4'h2));
    @(negedge clk);
    idle_lanes();
    set_lane(0, 1, 0, 32'hB040, 0);
    #1;
    chk("R10 load blocked valid", 128'(creq_valid), 128'(0));
    chk("R10 load blocked ready", 128'(lane_ready), 128'(0));
    @(negedge clk);
    crsp_valid = 1'b1;
    for (int k = 0; k < 4; k++) crsp_data[k*32 +: 32] = rw(32'hB000 + 32'(4*k));
    #1;
    chk("R10 blocked during beat", 128'(creq_valid), 128'(0));
    @(negedge clk);
    crsp_valid = 1'b0;
    #1;
    chk("R10 first rsp", 128'(lane_rsp_data[31:0]), 128'(rw(32'hB000)));
    chk("R10 unblocked", 128'(lane_ready), 128'(4'h1));
    @(negedge clk);
    idle_lanes();
    for (int k = 1; k < 5; k++)
      do_rsp("R10 in order", 32'hB000 + 32'(16*k), 4'h1, 32'hB000 + 32'(16*k), 0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule